// File: doc/BRIEF.md
# Drift-Compensated Nanosecond Time Counter

This block keeps a 64-bit time-of-day value in nanoseconds for hardware timestamping. The counter does not step on every clock. A 32-bit fractional accumulator adds a programmed addend on each clock, and each carry out of the accumulator moves the time forward by a programmed reference period. Software trims the rate in parts per billion by raising or lowering the addend. The usual correction is `addend * ppb / 1e9`.

A bypass mode steps the time by the period on every clock. A soft-reset control clears the time and the accumulator, and clearing the enable bit freezes both.

Software reaches the block through a simple word-addressed register port. The 64-bit time is read and written as two 32-bit halves, and the low half always goes first. Reading the low half takes a snapshot of the high half. Writing the high half loads the whole 64-bit value. The current time goes to neighbouring blocks as a registered bus. A one-cycle strobe marks every step.

Top module: `tod_counter`

## Requirements
- R1: While `rst` is high and in the cycle after it, `time_now`, `tick` and `rdata` are 0. After reset the control word and the addend are 0, so the timer is disabled.
- R2: When the enable bit (control bit 2) is set and bypass (control bit 3) is clear, the accumulator adds the addend modulo 2^32 on every clock. On a clock where that addition carries out of bit 31, `time_now` grows by the period field (control bits 25:16), and `tick` is high for that one cycle.
- R3: When enable and bypass are both set, `time_now` grows by the period on every clock and the accumulator holds. `tick` is high on every step.
- R4: When the enable bit is clear, `time_now` and the accumulator hold their values and `tick` stays low.
- R5: While the soft-reset bit (control bit 5) is set, `time_now` and the accumulator are cleared on every clock. The soft reset takes priority over every other update.
- R6: A read of address 1 returns `time_now[31:0]` and captures `time_now[63:32]`. A later read of address 2 returns the captured value, even if the time has moved since.
- R7: A write to address 1 only stages the low half and leaves `time_now` unchanged. A write to address 2 loads {written data, staged low half} into `time_now` on the next clock.
- R8: The load from a write to address 2 takes priority over a step in the same clock. In that clock `tick` stays low.
- R9: Address 0 reads back the control word. Address 3 reads back the addend. Address 4 reads the current accumulator. Any other address reads 0.
- R10: `rdata` is registered. It takes the value of the addressed register as it stood at the clock edge where `rd_en` was high, and it holds that value until the next read.
- R11: A write to the control word or the addend changes the stepping from the clock after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Word address: 0 control, 1 time low, 2 time high, 3 addend, 4 accumulator |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| time_now | output | 64 | Current time in nanoseconds |
| tick | output | 1 | One-cycle strobe on each time step |

## Verification
The rate logic is tried with several addends:
- an addend of one half, which must give exactly one step every two clocks;
- an odd addend near one quarter, whose carries fall irregularly, which catches a carry taken from the wrong bit or a lost remainder;
- an all-ones addend, which carries on almost every clock.

Bypass and disable runs separate the three stepping modes. Coherence and priority are tried in three ways:
- a low-half read followed by a high-half read after the time has moved, which shows whether the high half comes from the snapshot;
- a load written to land in the same clock as a bypass step, which shows whether the load wins over the step;
- soft reset applied while the timer runs.

// File: rtl/tod_pkg.sv
package tod_pkg;
  localparam int REG_W     = 32;
  localparam int ADDR_W    = 3;
  localparam int PERIOD_W  = 10;
  localparam int PERIOD_LSB = 16;
  localparam int EN_BIT    = 2;
  localparam int BYP_BIT   = 3;
  localparam int SRST_BIT  = 5;

  typedef enum logic [ADDR_W-1:0] {
    A_CTRL  = 3'd0,
    A_TLO   = 3'd1,
    A_THI   = 3'd2,
    A_ADDND = 3'd3,
    A_ACCUM = 3'd4
  } reg_addr_e;
endpackage

// File: rtl/tod_accum.sv
module tod_accum #(
  parameter int ACC_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             clear,
  input  logic [ACC_W-1:0] addend,
  output logic [ACC_W-1:0] acc,
  output logic             carry
);
  logic [ACC_W:0] sum;

  assign sum   = {1'b0, acc} + {1'b0, addend};
  assign carry = sum[ACC_W];

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      acc <= '0;
    end else if (run) begin
      acc <= sum[ACC_W-1:0];
    end
  end

  // R2: the accumulator advances by the addend modulo 2^ACC_W
  a_r2_accum_adds: assert property (@(posedge clk) disable iff (rst)
    (run && !clear) |=> (acc == $past(acc) + $past(addend)));

  // R5: soft reset empties the accumulator
  a_r5_accum_clear: assert property (@(posedge clk) disable iff (rst)
    clear |=> (acc == '0));
endmodule

// File: rtl/tod_step.sv
module tod_step #(
  parameter int TIME_W   = 64,
  parameter int PERIOD_W = 10
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                enable,
  input  logic                bypass,
  input  logic                clear,
  input  logic                carry,
  input  logic [PERIOD_W-1:0] period,
  input  logic                load,
  input  logic [TIME_W-1:0]   load_val,
  output logic [TIME_W-1:0]   count,
  output logic                tick
);
  logic step;

  assign step = enable && (bypass || carry);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      count <= '0;
      tick  <= 1'b0;
    end else if (load) begin
      count <= load_val;
      tick  <= 1'b0;
    end else if (step) begin
      count <= count + TIME_W'(period);
      tick  <= 1'b1;
    end else begin
      tick  <= 1'b0;
    end
  end

  // R4: a disabled timer holds its time
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    (!enable && !clear && !load) |=> ($stable(count) && !tick));

  // R3: bypass steps by the period on every clock
  a_r3_bypass_step: assert property (@(posedge clk) disable iff (rst)
    (enable && bypass && !clear && !load) |=> (count == $past(count) + TIME_W'($past(period))));

  // R5: soft reset clears the time
  a_r5_time_clear: assert property (@(posedge clk) disable iff (rst)
    clear |=> (count == '0 && !tick));

  // R7, R8: a high-half write loads the full value and suppresses the strobe
  a_r8_load_wins: assert property (@(posedge clk) disable iff (rst)
    (load && !clear) |=> (count == $past(load_val) && !tick));
endmodule

// File: rtl/tod_regs.sv
module tod_regs
  import tod_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int ACC_W  = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [REG_W-1:0]    wdata,
  input  logic [TIME_W-1:0]   count,
  input  logic [ACC_W-1:0]    acc,
  output logic [REG_W-1:0]    rdata,
  output logic                enable,
  output logic                bypass,
  output logic                clear,
  output logic [PERIOD_W-1:0] period,
  output logic [ACC_W-1:0]    addend,
  output logic                load,
  output logic [TIME_W-1:0]   load_val
);
  localparam int HI_W = TIME_W - REG_W;

  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] lo_stage_q;
  logic [HI_W-1:0]  hi_shadow_q;

  assign enable   = ctrl_q[EN_BIT];
  assign bypass   = ctrl_q[BYP_BIT];
  assign clear    = ctrl_q[SRST_BIT];
  assign period   = ctrl_q[PERIOD_LSB +: PERIOD_W];
  assign load     = wr_en && (addr == A_THI);
  assign load_val = {wdata[HI_W-1:0], lo_stage_q};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q     <= '0;
      addend     <= '0;
      lo_stage_q <= '0;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:  ctrl_q     <= wdata;
        A_TLO:   lo_stage_q <= wdata;
        A_ADDND: addend     <= wdata[ACC_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata       <= '0;
      hi_shadow_q <= '0;
    end else if (rd_en) begin
      case (addr)
        A_CTRL:  rdata <= ctrl_q;
        A_TLO: begin
          rdata       <= count[REG_W-1:0];
          hi_shadow_q <= count[TIME_W-1:REG_W];
        end
        A_THI:   rdata <= REG_W'(hi_shadow_q);
        A_ADDND: rdata <= REG_W'(addend);
        A_ACCUM: rdata <= REG_W'(acc);
        default: rdata <= '0;
      endcase
    end
  end

  // R6: a low-half read snapshots the high half
  a_r6_snapshot: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == A_TLO) |=> (hi_shadow_q == $past(count[TIME_W-1:REG_W])));

  // R10: read data holds between reads
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));
endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter int TIME_W = 64,
  parameter int ACC_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [REG_W-1:0]  wdata,
  output logic [REG_W-1:0]  rdata,
  output logic [TIME_W-1:0] time_now,
  output logic              tick
);
  logic                enable, bypass, clear, load, carry;
  logic [PERIOD_W-1:0] period;
  logic [ACC_W-1:0]    addend, acc;
  logic [TIME_W-1:0]   load_val;

  tod_regs #(.TIME_W(TIME_W), .ACC_W(ACC_W)) regs_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .count(time_now), .acc(acc), .rdata(rdata),
    .enable(enable), .bypass(bypass), .clear(clear), .period(period),
    .addend(addend), .load(load), .load_val(load_val)
  );

  tod_accum #(.ACC_W(ACC_W)) accum_i (
    .clk(clk), .rst(rst), .run(enable && !bypass), .clear(clear),
    .addend(addend), .acc(acc), .carry(carry)
  );

  tod_step #(.TIME_W(TIME_W), .PERIOD_W(PERIOD_W)) step_i (
    .clk(clk), .rst(rst), .enable(enable), .bypass(bypass), .clear(clear),
    .carry(carry), .period(period), .load(load), .load_val(load_val),
    .count(time_now), .tick(tick)
  );

  // R2: the strobe marks a step of exactly one period
  a_r2_tick_step: assert property (@(posedge clk) disable iff (rst)
    tick |-> (time_now == $past(time_now) + TIME_W'($past(period))));
endmodule

// File: tb/tod_counter_tb_top.sv
module tod_counter_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [2:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [63:0] time_now;
  logic        tick;

  int checks = 0, fails = 0;
  bit done = 0;

  tod_counter dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .time_now(time_now), .tick(tick)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural reference model
  logic [31:0] m_ctrl, m_add, m_stage, m_acc, m_shadow, m_rdata;
  logic [63:0] m_cnt;
  logic        m_tick;

  always @(posedge clk) begin
    logic [32:0] sum;
    logic [63:0] n_cnt;
    logic [31:0] n_acc;
    logic        n_tick;
    logic        en, byp, sr;
    if (rst) begin
      m_ctrl = 0; m_add = 0; m_stage = 0; m_acc = 0; m_shadow = 0;
      m_rdata = 0; m_cnt = 0; m_tick = 0;
    end else begin
      en = m_ctrl[2]; byp = m_ctrl[3]; sr = m_ctrl[5];
      sum = {1'b0, m_acc} + {1'b0, m_add};
      n_cnt = m_cnt; n_acc = m_acc; n_tick = 0;
      if (sr) begin
        n_cnt = 0; n_acc = 0;
      end else begin
        if (en && !byp) n_acc = sum[31:0];
        if (wr_en && addr == 3'd2) n_cnt = {wdata, m_stage};
        else if (en && (byp || sum[32])) begin
          n_cnt = m_cnt + 64'(m_ctrl[25:16]);
          n_tick = 1;
        end
      end
      if (rd_en) begin
        case (addr)
          3'd0: m_rdata = m_ctrl;
          3'd1: begin m_rdata = m_cnt[31:0]; m_shadow = m_cnt[63:32]; end
          3'd2: m_rdata = m_shadow;
          3'd3: m_rdata = m_add;
          3'd4: m_rdata = m_acc;
          default: m_rdata = 0;
        endcase
      end
      if (wr_en) begin
        case (addr)
          3'd0: m_ctrl = wdata;
          3'd1: m_stage = wdata;
          3'd3: m_add = wdata;
          default: ;
        endcase
      end
      m_cnt = n_cnt; m_acc = n_acc; m_tick = n_tick;
    end
  end

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // compare on every clock, away from the edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check64("R2/R3/R4/R5 time_now", time_now, m_cnt);
      check64("R2/R3 tick", {63'd0, tick}, {63'd0, m_tick});
      check64("R10 rdata", {32'd0, rdata}, {32'd0, m_rdata});
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_en = 1; addr = a;
    @(negedge clk);
    rd_en = 0;
    d = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  logic [31:0] v, lo;
  logic [63:0] t0;

  initial begin
    idle(3);
    // R1: reset state
    check64("R1 time_now in reset", time_now, 64'd0);
    check64("R1 tick in reset", {63'd0, tick}, 64'd0);
    @(negedge clk); rst = 0;
    idle(1);
    check64("R1 time_now after reset", time_now, 64'd0);
    rd(3'd0, v); check64("R1 ctrl reset", {32'd0, v}, 64'd0);
    idle(5);
    check64("R4 disabled after reset", time_now, 64'd0);

    // R2: addend of one half, period 8: one step per two clocks
    wr(3'd3, 32'h8000_0000);
    wr(3'd0, (32'd8 << 16) | 32'h4);
    t0 = time_now;
    idle(20);
    check64("R2 half addend rate", time_now - t0, 64'd80);
    // R9: readbacks
    rd(3'd0, v); check64("R9 ctrl readback", {32'd0, v}, {32'd0, (32'd8 << 16) | 32'h4});
    rd(3'd3, v); check64("R9 addend readback", {32'd0, v}, 64'h8000_0000);
    rd(3'd4, v); check64("R9 accum readback", {32'd0, v}, {32'd0, m_rdata});
    rd(3'd6, v); check64("R9 unmapped reads 0", {32'd0, v}, 64'd0);

    // R11: irregular addend, period 3
    wr(3'd3, 32'h4000_0001);
    wr(3'd0, (32'd3 << 16) | 32'h4);
    idle(60);
    // all-ones addend
    wr(3'd3, 32'hFFFF_FFFF);
    idle(30);

    // R3: bypass, period 5
    wr(3'd0, (32'd5 << 16) | 32'hC);
    t0 = time_now;
    idle(10);
    check64("R3 bypass rate", time_now - t0, 64'd50);

    // R4: disabled holds
    wr(3'd0, (32'd5 << 16));
    t0 = time_now;
    idle(10);
    check64("R4 hold while disabled", time_now, t0);

    // R7: staged low write does not touch time, high write loads
    wr(3'd1, 32'hFFFF_FFF0);
    check64("R7 low write no effect", time_now, t0);
    wr(3'd2, 32'h0000_0001);
    check64("R7 load value", time_now, 64'h0000_0001_FFFF_FFF0);

    // R6: coherent snapshot across a low-word rollover
    wr(3'd0, (32'd7 << 16) | 32'hC);
    idle(1);
    rd(3'd1, lo);
    idle(4);
    rd(3'd2, v);
    check64("R6 snapshot high", {v, lo}, {32'h1, 32'hFFFF_FFF0 + 32'd14});
    check64("R6 time moved on", {63'd0, time_now[63:32] == 32'h2}, 64'd1);

    // R8: load lands in the same clock as a bypass step
    wr(3'd1, 32'h0000_1000);
    wr(3'd2, 32'h0000_00AB);
    check64("R8 load wins over step", time_now, 64'h0000_00AB_0000_1000);
    check64("R8 no tick on load", {63'd0, tick}, 64'd0);

    // R5: soft reset while running
    wr(3'd0, (32'd7 << 16) | 32'h24);
    idle(5);
    check64("R5 soft reset clears time", time_now, 64'd0);
    rd(3'd4, v); check64("R5 accum cleared", {32'd0, v}, 64'd0);
    wr(3'd3, 32'h9000_0000);
    wr(3'd0, (32'd2 << 16) | 32'h4);
    idle(40);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule